// File: doc/BRIEF.md
# SPI Command Decoder for a CAN Controller Register File

This block is the serial front end of a CAN controller. An SPI master drives a chip select, a serial clock and a data line. The block decodes a one-byte opcode and then serves the master from a 128-byte register space. That space holds the mode control and mode status registers, the interrupt enable and flag registers, and the transmit and receive buffers. Plain commands read, write or masked-modify registers and stream through consecutive addresses. Fast commands go straight to a transmit or receive buffer, or raise transmit requests, without an address byte. A reset command returns the whole space to its power-up contents.

The CAN protocol engine is not part of the block. A simple side write port takes its place, so that received frames and event flags can be placed into the register space. An active-low interrupt line reports any flag whose enable bit is set. All SPI inputs are resynchronised to the system clock, which must run several times faster than the serial clock.

Top module: `can_spi_cmd`

## Requirements
- R1: After `rst`, the control register (address 0x0F) reads 0x87, so that control AND 0x17 gives 0x07. The status register (0x0E) reads 0x80, which means configuration mode. Every other register reads 0x00 and `irq_n` is high.
- R2: Opcode 0x02 is followed by an address byte, and each later complete byte is written to that address and then to the next ones. Address bit 7 is ignored, and the address wraps from 0x7F to 0x00.
- R3: Opcode 0x03 is followed by an address byte, and the register bytes are then returned from that address upward, MSB first, in SPI mode 0. `spi_miso_oe` is high only in a data phase that returns bytes. It is low during the opcode and address bytes.
- R4: Opcode 0x05 takes an address, a mask byte and a data byte. Only the bits set in the mask take the data value. Bytes after the data byte have no effect.
- R5: Opcode 0x40+2n, for n = 0, 1 or 2, writes the following bytes from address 0x31+0x10·n upward.
- R6: Opcode 0x90 returns bytes from 0x61 upward and opcode 0x94 returns bytes from 0x71 upward. When chip select then rises, bit 0 (for 0x90) or bit 1 (for 0x94) of the interrupt flag register at 0x2C is cleared.
- R7: Opcode 0x80 OR m, with m a 3-bit mask, sets bit 3 of the buffer control register at 0x30+0x10·n for each set bit n of m. It leaves the other buffers unchanged.
- R8: Control bits [7:5] request a mode: 000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration. Status bits [7:5] take a legal request one cycle after it is written. A request of 101 to 111 leaves the status unchanged. The status register cannot be written, and its bits [4:0] read 0.
- R9: Opcode 0xC0 restores the R1 contents as soon as its last bit is received.
- R10: If chip select rises before a command's final byte is complete, the unfinished byte changes no register.
- R11: Any other opcode, including 0x46 and 0x00, is ignored together with all bytes that follow until chip select rises.
- R12: `irq_n` is low exactly when the AND of the enable register (0x2B) and the flag register (0x2C) is nonzero.
- R13: A side port write stores `side_data` at `side_addr` in the cycle after it is presented. A side port write to 0x0E is ignored. If an SPI write reaches the same address in the same cycle, the SPI write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the SPI clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low (mode 0) |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select; a rising edge ends the command |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | High while the block drives `spi_miso` |
| side_we | input | 1 | Side port write strobe |
| side_addr | input | 7 | Side port register address |
| side_data | input | 8 | Side port write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions run on every cycle. They check four things: the data output is never enabled after chip select has been high for several cycles, a transmit request pulse always leaves its request bit set, a receive-flag clear pulse always leaves that flag clear, and the mode status always follows legal requests and holds on illegal ones. Only the bench scenarios can show opcode decoding, address auto-increment and wrap, masked modify, the byte order on the serial output, abandoned commands, ignored opcodes and the effect of soft reset. They check these against a register model kept in the bench. Random write-then-read bursts compare the whole data path with that model.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;

    localparam int ADDR_W   = 7;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int NUM_TXB  = 3;
    localparam int NUM_RXB  = 2;

    localparam logic [ADDR_W-1:0] A_STAT     = 7'h0E;
    localparam logic [ADDR_W-1:0] A_CTRL     = 7'h0F;
    localparam logic [ADDR_W-1:0] A_IE       = 7'h2B;
    localparam logic [ADDR_W-1:0] A_IF       = 7'h2C;
    localparam logic [ADDR_W-1:0] TXB_BASE   = 7'h30;
    localparam logic [ADDR_W-1:0] RXB_BASE   = 7'h60;
    localparam logic [ADDR_W-1:0] BUF_STRIDE = 7'h10;

    localparam logic [7:0] CTRL_RESET = 8'h87;
    localparam logic [2:0] MODE_CONF  = 3'b100;
    localparam int         TXREQ_BIT  = 3;

    typedef enum logic [2:0] {
        PH_OP, PH_ADDR, PH_WDATA, PH_RDATA, PH_MASK, PH_BDATA, PH_IDLE
    } phase_t;

    typedef enum logic [2:0] {
        C_NONE, C_WRITE, C_READ, C_BITMOD, C_LOADTX, C_RXREAD, C_RTS, C_RESET
    } cmd_t;

    typedef struct packed {
        cmd_t              kind;
        logic [ADDR_W-1:0] start;
        logic [2:0]        sel;
    } decode_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        mask;
        logic [7:0]        data;
    } wr_req_t;

    function automatic logic [ADDR_W-1:0] txctrl_addr(input int n);
        return ADDR_W'(int'(TXB_BASE) + n * int'(BUF_STRIDE));
    endfunction

    function automatic logic [7:0] reset_value(input logic [ADDR_W-1:0] a);
        return (a == A_CTRL) ? CTRL_RESET : 8'h00;
    endfunction

    function automatic decode_t decode_op(input logic [7:0] op);
        decode_t d;
        d.kind  = C_NONE;
        d.start = '0;
        d.sel   = '0;
        if (op == 8'h02)      d.kind = C_WRITE;
        else if (op == 8'h03) d.kind = C_READ;
        else if (op == 8'h05) d.kind = C_BITMOD;
        else if (op == 8'hC0) d.kind = C_RESET;
        else if (op[7:3] == 5'b01000 && !op[0] && int'(op[2:1]) < NUM_TXB) begin
            d.kind  = C_LOADTX;
            d.start = txctrl_addr(int'(op[2:1])) + 7'd1;
        end else if (op == 8'h90 || op == 8'h94) begin
            d.kind  = C_RXREAD;
            d.start = RXB_BASE + (op[2] ? BUF_STRIDE : 7'h00) + 7'd1;
            d.sel   = op[2] ? 3'b010 : 3'b001;
        end else if (op[7:3] == 5'b10000) begin
            d.kind = C_RTS;
            d.sel  = op[2:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/spi_sampler.sv
module spi_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic mosi,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic cs_act,
    output logic cs_end
);
    logic [STAGES-1:0] sck_p, mosi_p, csn_p;
    logic              sck_d, csn_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            mosi_p <= '0;
            csn_p  <= '1;
            sck_d  <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sck_p  <= {sck_p[STAGES-2:0], sck};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
            csn_p  <= {csn_p[STAGES-2:0], cs_n};
            sck_d  <= sck_p[STAGES-1];
            csn_d  <= csn_p[STAGES-1];
        end
    end

    assign cs_act   = !csn_p[STAGES-1];
    assign cs_end   = csn_p[STAGES-1] && !csn_d;
    assign sck_rise = cs_act && sck_p[STAGES-1] && !sck_d;
    assign sck_fall = cs_act && !sck_p[STAGES-1] && sck_d;
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import can_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              cs_act,
    input  logic              cs_end,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic [NUM_TXB-1:0] set_txreq,
    output logic [NUM_RXB-1:0] clr_rxif,
    output logic              soft_reset,
    output logic              miso,
    output logic              miso_oe
);
    phase_t            phase_q;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        mask_q, tx_q;
    logic [6:0]        sh_q;
    logic [2:0]        bit_q;
    logic [NUM_RXB-1:0] rx_pend_q;
    logic [7:0]        byte_in;
    logic              byte_done;
    decode_t           dec;

    assign byte_in   = {sh_q, mosi_s};
    assign byte_done = sck_rise && (bit_q == 3'd7);
    assign dec       = decode_op(byte_in);

    always_comb begin
        case (phase_q)
            PH_OP:   rd_addr = dec.start;
            PH_ADDR: rd_addr = byte_in[ADDR_W-1:0];
            default: rd_addr = addr_q;
        endcase
    end

    always_comb begin
        wr         = '0;
        set_txreq  = '0;
        soft_reset = 1'b0;
        clr_rxif   = cs_end ? rx_pend_q : '0;
        if (byte_done) begin
            case (phase_q)
                PH_OP: begin
                    if (dec.kind == C_RTS)   set_txreq  = dec.sel[NUM_TXB-1:0];
                    if (dec.kind == C_RESET) soft_reset = 1'b1;
                end
                PH_WDATA: wr = '{en: 1'b1, addr: addr_q, mask: 8'hFF, data: byte_in};
                PH_BDATA: wr = '{en: 1'b1, addr: addr_q, mask: mask_q, data: byte_in};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            phase_q   <= PH_OP;
            cmd_q     <= C_NONE;
            bit_q     <= '0;
            sh_q      <= '0;
            rx_pend_q <= '0;
            if (rst) begin
                addr_q <= '0;
                mask_q <= '0;
                tx_q   <= '0;
            end
        end else if (sck_rise) begin
            sh_q  <= byte_in[6:0];
            bit_q <= bit_q + 3'd1;
            if (byte_done) begin
                case (phase_q)
                    PH_OP: begin
                        cmd_q <= dec.kind;
                        case (dec.kind)
                            C_WRITE, C_READ, C_BITMOD: phase_q <= PH_ADDR;
                            C_LOADTX: begin
                                addr_q  <= dec.start;
                                phase_q <= PH_WDATA;
                            end
                            C_RXREAD: begin
                                tx_q      <= rd_data;
                                addr_q    <= dec.start + 7'd1;
                                rx_pend_q <= dec.sel[NUM_RXB-1:0];
                                phase_q   <= PH_RDATA;
                            end
                            default: phase_q <= PH_IDLE;
                        endcase
                    end
                    PH_ADDR: begin
                        case (cmd_q)
                            C_READ: begin
                                tx_q    <= rd_data;
                                addr_q  <= byte_in[ADDR_W-1:0] + 7'd1;
                                phase_q <= PH_RDATA;
                            end
                            C_BITMOD: begin
                                addr_q  <= byte_in[ADDR_W-1:0];
                                phase_q <= PH_MASK;
                            end
                            default: begin
                                addr_q  <= byte_in[ADDR_W-1:0];
                                phase_q <= PH_WDATA;
                            end
                        endcase
                    end
                    PH_WDATA: addr_q <= addr_q + 7'd1;
                    PH_RDATA: begin
                        tx_q   <= rd_data;
                        addr_q <= addr_q + 7'd1;
                    end
                    PH_MASK: begin
                        mask_q  <= byte_in;
                        phase_q <= PH_BDATA;
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end else if (sck_fall && bit_q != 3'd0) begin
            tx_q <= {tx_q[6:0], 1'b0};
        end
    end

    assign miso    = tx_q[7];
    assign miso_oe = (phase_q == PH_RDATA);
endmodule

// File: rtl/can_regfile.sv
module can_regfile
    import can_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    input  wr_req_t            wr,
    input  logic [NUM_TXB-1:0] set_txreq,
    input  logic [NUM_RXB-1:0] clr_rxif,
    input  logic               soft_reset,
    input  logic               side_we,
    input  logic [ADDR_W-1:0]  side_addr,
    input  logic [7:0]         side_data,
    output logic [2:0]         ctrl_req,
    output logic [2:0]         mode,
    output logic [7:0]         ie_byte,
    output logic [7:0]         if_byte,
    output logic [NUM_TXB-1:0] txreq
);
    logic [7:0] mem [DEPTH];
    logic [2:0] mode_q;

    assign rd_data  = (rd_addr == A_STAT) ? {mode_q, 5'b0} : mem[rd_addr];
    assign ctrl_req = mem[A_CTRL][7:5];
    assign mode     = mode_q;
    assign ie_byte  = mem[A_IE];
    assign if_byte  = mem[A_IF];

    for (genvar n = 0; n < NUM_TXB; n++) begin : g_txreq
        assign txreq[n] = mem[txctrl_addr(n)][TXREQ_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || soft_reset) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= reset_value(ADDR_W'(i));
            mode_q <= MODE_CONF;
        end else begin
            if (side_we && side_addr != A_STAT) mem[side_addr] <= side_data;
            if (wr.en && wr.addr != A_STAT)
                mem[wr.addr] <= (mem[wr.addr] & ~wr.mask) | (wr.data & wr.mask);
            for (int n = 0; n < NUM_TXB; n++)
                if (set_txreq[n]) mem[txctrl_addr(n)][TXREQ_BIT] <= 1'b1;
            for (int k = 0; k < NUM_RXB; k++)
                if (clr_rxif[k]) mem[A_IF][k] <= 1'b0;
            if (mem[A_CTRL][7:5] <= MODE_CONF) mode_q <= mem[A_CTRL][7:5];
        end
    end
endmodule

// File: rtl/can_spi_cmd.sv
module can_spi_cmd
    import can_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              side_we,
    input  logic [ADDR_W-1:0] side_addr,
    input  logic [7:0]        side_data,
    output logic              irq_n
);
    logic               sck_rise, sck_fall, mosi_s, cs_act, cs_end, soft_rst;
    logic [ADDR_W-1:0]  rd_addr;
    logic [7:0]         rd_data, ie_byte, if_byte;
    logic [2:0]         ctrl_req, mode;
    logic [NUM_TXB-1:0] set_txreq, txreq;
    logic [NUM_RXB-1:0] clr_rxif;
    wr_req_t            wr;

    spi_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst(rst), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .cs_act(cs_act), .cs_end(cs_end)
    );

    spi_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .mosi_s(mosi_s), .cs_act(cs_act), .cs_end(cs_end), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr(wr), .set_txreq(set_txreq), .clr_rxif(clr_rxif),
        .soft_reset(soft_rst), .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    can_regfile u_regs (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data), .wr(wr),
        .set_txreq(set_txreq), .clr_rxif(clr_rxif), .soft_reset(soft_rst),
        .side_we(side_we), .side_addr(side_addr), .side_data(side_data),
        .ctrl_req(ctrl_req), .mode(mode), .ie_byte(ie_byte), .if_byte(if_byte),
        .txreq(txreq)
    );

    assign irq_n = ~|(ie_byte & if_byte);
endmodule

// File: rtl/can_spi_cmd_chk.sv
module can_spi_cmd_chk #(
    parameter int NTX = 3,
    parameter int NRX = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           cs_n,
    input logic           miso_oe,
    input logic           soft_reset,
    input logic [2:0]     ctrl_req,
    input logic [2:0]     mode,
    input logic [NTX-1:0] set_txreq,
    input logic [NTX-1:0] txreq,
    input logic [NRX-1:0] clr_rxif,
    input logic [NRX-1:0] rxif
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd4) age <= age + 3'd1;
    end

    // R3: output enable is off once chip select has been high for four samples
    p_oe_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> !miso_oe);

    // R8: a legal request reaches the status field one cycle later
    p_mode_follow_r8: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && !$past(soft_reset) && $past(ctrl_req) <= 3'd4)
        |-> mode == $past(ctrl_req));

    // R8: an illegal request leaves the status field alone
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && !$past(soft_reset) && $past(ctrl_req) > 3'd4)
        |-> $stable(mode));

    for (genvar n = 0; n < NTX; n++) begin : g_tx
        // R7: a request pulse leaves the request bit set
        p_txreq_set_r7: assert property (@(posedge clk) disable iff (rst)
            (age != 3'd0 && $past(set_txreq[n])) |-> txreq[n]);
    end

    for (genvar k = 0; k < NRX; k++) begin : g_rx
        // R6: a clear pulse leaves the receive flag clear
        p_rxif_clr_r6: assert property (@(posedge clk) disable iff (rst)
            (age != 3'd0 && $past(clr_rxif[k])) |-> !rxif[k]);
    end
endmodule

bind can_spi_cmd can_spi_cmd_chk #(.NTX(3), .NRX(2)) u_chk (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .miso_oe(spi_miso_oe),
    .soft_reset(soft_rst), .ctrl_req(ctrl_req), .mode(mode),
    .set_txreq(set_txreq), .txreq(txreq), .clr_rxif(clr_rxif),
    .rxif(if_byte[1:0])
);

// File: tb/can_spi_cmd_test.sv
module can_spi_cmd_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst, sck, mosi, cs_n, side_we;
    logic [6:0] side_addr;
    logic [7:0] side_data;
    wire  miso, miso_oe, irq_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] m [128];
    logic [2:0] mmode;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #4 clk = ~clk;

    can_spi_cmd uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .side_we(side_we),
        .side_addr(side_addr), .side_data(side_data), .irq_n(irq_n)
    );

    function automatic logic [7:0] exp_reg(input logic [6:0] a);
        return (a == 7'h0E) ? {mmode, 5'b0} : m[a];
    endfunction

    function automatic logic exp_irq();
        return ~|(m[7'h2B] & m[7'h2C]);
    endfunction

    function automatic logic [7:0] bitmod(input logic [7:0] o, mk, d);
        return (o & ~mk) | (d & mk);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m[i] = 8'h00;
        m[7'h0F] = 8'h87;
        mmode = 3'b100;
    endtask

    task automatic mwrite(input logic [6:0] a, input logic [7:0] d);
        if (a != 7'h0E) m[a] = d;
        if (m[7'h0F][7:5] <= 3'd4) mmode = m[7'h0F][7:5];
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cs_lo();
        wait_clk(1);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic spi_write(input logic [7:0] a, input int n);
        logic [7:0] r;
        cs_lo();
        xfer(8'h02, r);
        xfer(a, r);
        for (int i = 0; i < n; i++) xfer(wbuf[i], r);
        cs_hi();
        for (int i = 0; i < n; i++) mwrite(7'(a[6:0] + 7'(i)), wbuf[i]);
    endtask

    task automatic spi_read(input logic [7:0] a, input int n);
        logic [7:0] r;
        cs_lo();
        xfer(8'h03, r);
        chk("R3 oe low after opcode", {7'b0, miso_oe}, 8'h00);
        xfer(a, r);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        cs_hi();
    endtask

    task automatic expect_regs(input string tag, input logic [6:0] a, input int n);
        spi_read({1'b0, a}, n);
        for (int i = 0; i < n; i++) chk(tag, rbuf[i], exp_reg(7'(a + 7'(i))));
    endtask

    task automatic side_wr(input logic [6:0] a, input logic [7:0] d);
        side_addr = a;
        side_data = d;
        side_we   = 1'b1;
        wait_clk(1);
        side_we = 1'b0;
        wait_clk(1);
        mwrite(a, d);
    endtask

    task automatic single_op(input logic [7:0] op);
        logic [7:0] r;
        cs_lo();
        xfer(op, r);
        cs_hi();
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        int dummy;
        dummy = $urandom(32'd4242);
        rst = 1'b1; sck = 1'b0; mosi = 1'b0; cs_n = 1'b1;
        side_we = 1'b0; side_addr = '0; side_data = '0;
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1: reset contents
        spi_read(8'h0F, 1);
        chk("R1 ctrl and 0x17", rbuf[0] & 8'h17, 8'h07);
        chk("R1 ctrl reset", rbuf[0], 8'h87);
        expect_regs("R1 status reset", 7'h0E, 1);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // R2 / R3: burst write then burst read
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h5A ^ 8'(i * 37);
        spi_write(8'h20, 4);
        expect_regs("R2 burst write", 7'h20, 4);
        wbuf[0] = 8'hC3;
        spi_write(8'hA5, 1);
        expect_regs("R2 address bit 7 ignored", 7'h25, 1);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        spi_write(8'h7E, 3);
        expect_regs("R2 wrap past 0x7F", 7'h7E, 3);

        // R4: masked modify, trailing byte ignored
        wbuf[0] = 8'hA5; wbuf[1] = 8'h66;
        spi_write(8'h22, 2);
        cs_lo();
        xfer(8'h05, r); xfer(8'h22, r); xfer(8'h0F, r); xfer(8'h3C, r); xfer(8'hFF, r);
        cs_hi();
        m[7'h22] = bitmod(m[7'h22], 8'h0F, 8'h3C);
        chk("R4 masked result", m[7'h22], 8'hAC);
        expect_regs("R4 bit modify", 7'h22, 2);

        // R5: transmit buffer load
        cs_lo();
        xfer(8'h42, r); xfer(8'hD1, r); xfer(8'hD2, r); xfer(8'hD3, r);
        cs_hi();
        mwrite(7'h41, 8'hD1); mwrite(7'h42, 8'hD2); mwrite(7'h43, 8'hD3);
        expect_regs("R5 load buffer 1", 7'h40, 4);
        cs_lo();
        xfer(8'h44, r); xfer(8'hE7, r);
        cs_hi();
        mwrite(7'h51, 8'hE7);
        expect_regs("R5 load buffer 2", 7'h50, 2);

        // R13 + R6: side port loads receive buffers and flags
        for (int i = 0; i < 4; i++) side_wr(7'(8'h61 + i), 8'hB0 + 8'(i));
        for (int i = 0; i < 2; i++) side_wr(7'(8'h71 + i), 8'hC0 + 8'(i));
        side_wr(7'h2C, 8'h03);
        side_wr(7'h0E, 8'hFF);
        expect_regs("R13 side write status ignored", 7'h0E, 1);
        cs_lo();
        xfer(8'h90, r);
        chk("R3 oe high in data phase", {7'b0, miso_oe}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, r);
            chk("R6 rx buffer 0 stream", r, 8'hB0 + 8'(i));
        end
        cs_hi();
        m[7'h2C][0] = 1'b0;
        expect_regs("R6 flag 0 cleared", 7'h2C, 1);
        cs_lo();
        xfer(8'h94, r);
        for (int i = 0; i < 2; i++) begin
            xfer(8'h00, r);
            chk("R6 rx buffer 1 stream", r, 8'hC0 + 8'(i));
        end
        cs_hi();
        m[7'h2C][1] = 1'b0;
        expect_regs("R6 flag 1 cleared", 7'h2C, 1);

        // R7: request to send on buffers 0 and 2
        wbuf[0] = 8'h01;
        spi_write(8'h30, 1);
        single_op(8'h85);
        m[7'h30][3] = 1'b1; m[7'h50][3] = 1'b1;
        spi_read(8'h30, 1); chk("R7 buffer 0 request", rbuf[0], 8'h09);
        spi_read(8'h40, 1); chk("R7 buffer 1 untouched", rbuf[0], exp_reg(7'h40));
        spi_read(8'h50, 1); chk("R7 buffer 2 request", rbuf[0], 8'h08);

        // R8: mode tracking
        wbuf[0] = 8'h40;
        spi_write(8'h0F, 1);
        spi_read(8'h0E, 1); chk("R8 loopback", rbuf[0], 8'h40);
        wbuf[0] = 8'hE0;
        spi_write(8'h0F, 1);
        spi_read(8'h0E, 1); chk("R8 illegal request holds", rbuf[0], 8'h40);
        wbuf[0] = 8'hFF;
        spi_write(8'h0E, 1);
        spi_read(8'h0E, 1); chk("R8 status read only", rbuf[0], 8'h40);
        wbuf[0] = 8'h60;
        spi_write(8'h0F, 1);
        expect_regs("R8 listen-only", 7'h0E, 2);

        // R12: interrupt line
        wbuf[0] = 8'h01;
        spi_write(8'h2B, 1);
        side_wr(7'h2C, 8'h01);
        chk("R12 irq asserted", {7'b0, irq_n}, {7'b0, exp_irq()});
        side_wr(7'h2C, 8'h02);
        chk("R12 irq masked", {7'b0, irq_n}, {7'b0, exp_irq()});

        // R10: abandoned commands
        cs_lo();
        xfer(8'h02, r); xfer(8'h20, r); xbits(8'hFF, 4, r);
        cs_hi();
        expect_regs("R10 partial write", 7'h20, 1);
        cs_lo();
        xfer(8'h05, r); xfer(8'h21, r); xfer(8'hFF, r); xbits(8'h00, 7, r);
        cs_hi();
        expect_regs("R10 partial modify", 7'h21, 1);

        // R11: unrecognised opcodes
        cs_lo();
        xfer(8'h46, r); xfer(8'h99, r); xfer(8'h98, r);
        cs_hi();
        expect_regs("R11 opcode 0x46", 7'h61, 2);
        cs_lo();
        xfer(8'h00, r); xfer(8'h02, r); xfer(8'h20, r); xfer(8'h77, r);
        cs_hi();
        expect_regs("R11 opcode 0x00", 7'h20, 1);

        // random write/read bursts
        for (int it = 0; it < 24; it++) begin
            logic [6:0] a;
            int n;
            a = 7'($urandom_range(16, 127));
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            spi_write({1'b0, a}, n);
            expect_regs("R2 random burst", a, n);
            chk("R12 random irq", {7'b0, irq_n}, {7'b0, exp_irq()});
        end

        // R9: soft reset
        single_op(8'hC0);
        model_reset();
        expect_regs("R9 soft reset", 7'h0E, 2);
        expect_regs("R9 soft reset data", 7'h20, 4);
        chk("R9 irq_n", {7'b0, irq_n}, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule